// File: doc/BRIEF.md
# Configuration Read Retry-Status Handler

This block sits in a root port between the host-side configuration access path and the downstream link. It accepts one configuration read at a time (a dword register index plus four byte enables), forwards it downstream, and waits for a completion. The completion carries one of four status codes and a 32-bit data word. Depending on that status, the block does one of three things: it returns the data, it makes up a reply, or it sends the same read downstream again.

A device that is still coming out of reset answers with retry status. The block can pass that condition up to software as a marker value, or it can retry the read on its own. Which one happens depends on a visibility enable and on whether the read covers the whole 16-bit identifier field at register 0, bytes 0 and 1. Retrying on its own is limited in two ways: by a programmable number of re-issues and by a programmable cycle budget. When either limit runs out, the read finishes with all-ones data and a sticky error flag is raised. Software clears that flag with a pulse.

Top module: `cfgrd_retry_handler`

## Requirements
- R1: `req_ready` is high only while no read is in progress. An accepted request produces a one-cycle `dn_valid` on the next cycle, carrying the accepted register index and byte enables.
- R2: A completion with status 0 (success) is returned on `rsp_data`. Each byte whose byte enable is clear is forced to 0x00.
- R3: A completion with status 2 (completer abort) or status 3 (unsupported request) is returned as 0xFFFFFFFF.
- R4: A retry-status completion (status 1) is answered to the host without another downstream request when all of these hold: `sw_vis_en` is 1, the register index is 0, and byte enables 0 and 1 are both set. In that case bytes 1:0 read 0x0001, bytes 3 and 2 read 0xFF when enabled and 0x00 otherwise. A full read therefore gives 0xFFFF0001.
- R5: With `sw_vis_en` at 0, a retry-status completion causes the same read to be sent downstream again.
- R6: With `sw_vis_en` at 1, a retry-status completion is also re-issued when the read is not at register 0 or does not enable both bytes 0 and 1.
- R7: At most `retry_max` re-issues happen per host read. A retry-status completion that arrives once that many re-issues have been made finishes the read with 0xFFFFFFFF and sets `err_flag`.
- R8: The cycle counter starts at 0 when a request is accepted and advances on every cycle until the response. A read still waiting with no completion once this counter has reached `timeout_cyc` finishes with 0xFFFFFFFF and sets `err_flag`.
- R9: `err_flag` stays set across later reads until a one-cycle `err_clr` pulse clears it.
- R10: The re-issue count and the cycle counter restart with every new host request.
- R11: A finished read produces a one-cycle `rsp_valid`, in the cycle after the completion or timeout that ended it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_vis_en | input | 1 | Pass retry status up to software as a marker value |
| retry_max | input | CNT_W | Maximum number of re-issues per host read |
| timeout_cyc | input | TMO_W | Cycle budget per host read |
| err_clr | input | 1 | Clears the sticky error flag |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_reg | input | REG_W | Dword register index |
| req_be | input | 4 | Byte enables |
| dn_valid | output | 1 | Downstream read issued (one cycle) |
| dn_reg | output | REG_W | Downstream register index |
| dn_be | output | 4 | Downstream byte enables |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 2 | 0 success, 1 retry, 2 abort, 3 unsupported |
| cpl_data | input | 32 | Completion data |
| rsp_valid | output | 1 | Host response (one cycle) |
| rsp_data | output | 32 | Host response data |
| err_flag | output | 1 | Sticky retry-limit or timeout error |

## Verification
The bench targets the narrow marker condition. It uses a full read and a half read at register 0, and also a read at register 0 missing byte 1 and a read at register 1. A design that tested only one byte enable, or ignored the index, would return the marker where it should retry. The retry limit is exercised at zero and at two re-issues, and the timeout with a silent device. A design with an off-by-one count would show one extra or one missing downstream request. A good read is then run straight after a failure, so a counter that is not cleared would end that read too early. A second request is held on the input while a read is in progress, so a design that accepts early would send the second index downstream while the first read is still outstanding.

// File: rtl/cfgrd_retry_handler.sv
module cfgrd_retry_handler #(
  parameter int REG_W = 10,
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_vis_en,
  input  logic [CNT_W-1:0] retry_max,
  input  logic [TMO_W-1:0] timeout_cyc,
  input  logic             err_clr,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [REG_W-1:0] req_reg,
  input  logic [3:0]       req_be,
  output logic             dn_valid,
  output logic [REG_W-1:0] dn_reg,
  output logic [3:0]       dn_be,
  input  logic             cpl_valid,
  input  logic [1:0]       cpl_status,
  input  logic [31:0]      cpl_data,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             err_flag
);

  localparam logic [1:0] CPL_OK    = 2'd0;
  localparam logic [1:0] CPL_RETRY = 2'd1;
  localparam logic [31:0] ONES     = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} state_t;

  state_t           state_q;
  logic [REG_W-1:0] reg_q;
  logic [3:0]       be_q;
  logic [CNT_W-1:0] tries_q;
  logic [TMO_W-1:0] timer_q;
  logic             rsp_valid_q;
  logic [31:0]      rsp_data_q;
  logic             err_q;

  logic [31:0] be_mask;
  logic [31:0] marker;
  logic        vid_hit;
  logic        give_up;
  logic        tmo_hit;

  assign be_mask = {{8{be_q[3]}}, {8{be_q[2]}}, {8{be_q[1]}}, {8{be_q[0]}}};
  assign marker  = {{8{be_q[3]}}, {8{be_q[2]}}, 16'h0001};
  assign vid_hit = sw_vis_en && (reg_q == '0) && (be_q[1:0] == 2'b11);
  assign give_up = tries_q >= retry_max;
  assign tmo_hit = timer_q >= timeout_cyc;

  assign req_ready = (state_q == IDLE);
  assign dn_valid  = (state_q == ISSUE);
  assign dn_reg    = reg_q;
  assign dn_be     = be_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign err_flag  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= IDLE;
      reg_q       <= '0;
      be_q        <= '0;
      tries_q     <= '0;
      timer_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (err_clr) err_q <= 1'b0;
      if (state_q != IDLE && timer_q != '1) timer_q <= timer_q + 1'b1;
      case (state_q)
        IDLE: begin
          if (req_valid) begin
            reg_q   <= req_reg;
            be_q    <= req_be;
            tries_q <= '0;
            timer_q <= '0;
            state_q <= ISSUE;
          end
        end
        ISSUE: state_q <= WAIT;
        WAIT: begin
          if (cpl_valid) begin
            if (cpl_status == CPL_OK) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= cpl_data & be_mask;
              state_q     <= IDLE;
            end else if (cpl_status != CPL_RETRY) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= ONES;
              state_q     <= IDLE;
            end else if (vid_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= marker;
              state_q     <= IDLE;
            end else if (give_up) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= ONES;
              err_q       <= 1'b1;
              state_q     <= IDLE;
            end else begin
              tries_q <= tries_q + 1'b1;
              state_q <= ISSUE;
            end
          end else if (tmo_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= ONES;
            err_q       <= 1'b1;
            state_q     <= IDLE;
          end
        end
        default: state_q <= IDLE;
      endcase
    end
  end

endmodule

module cfgrd_retry_handler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        dn_valid,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        err_flag,
  input logic        err_clr
);

  assert_accept_issues_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (dn_valid && !req_ready));

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !req_ready);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_no_issue_with_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !rsp_valid);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  assert_fail_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (rsp_valid && rsp_data == 32'hFFFF_FFFF));

endmodule

bind cfgrd_retry_handler cfgrd_retry_handler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .dn_valid(dn_valid), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .err_flag(err_flag), .err_clr(err_clr)
);

// File: tb/tb_cfgrd_retry_handler.sv
`timescale 1ns/1ps
module tb_cfgrd_retry_handler;

  localparam int REG_W = 10;
  localparam int CNT_W = 8;
  localparam int TMO_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sw_vis_en = 1'b0;
  logic [CNT_W-1:0] retry_max = 8'd4;
  logic [TMO_W-1:0] timeout_cyc = 16'd200;
  logic             err_clr = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [REG_W-1:0] req_reg = '0;
  logic [3:0]       req_be = 4'hF;
  logic             dn_valid;
  logic [REG_W-1:0] dn_reg;
  logic [3:0]       dn_be;
  logic             cpl_valid = 1'b0;
  logic [1:0]       cpl_status = 2'd0;
  logic [31:0]      cpl_data = 32'h0;
  logic             rsp_valid;
  logic [31:0]      rsp_data;
  logic             err_flag;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  cfgrd_retry_handler #(.REG_W(REG_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .sw_vis_en(sw_vis_en), .retry_max(retry_max),
    .timeout_cyc(timeout_cyc), .err_clr(err_clr), .req_valid(req_valid),
    .req_ready(req_ready), .req_reg(req_reg), .req_be(req_be),
    .dn_valid(dn_valid), .dn_reg(dn_reg), .dn_be(dn_be),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  int          m_st = 0;
  int          m_reg = 0;
  logic [3:0]  m_be = 4'h0;
  int          m_tries = 0;
  int          m_timer = 0;
  bit          m_rspv = 0;
  logic [31:0] m_rspd = 32'h0;
  bit          m_err = 0;
  string       m_tag = "R2";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rspv = 0; m_rspd = 0; m_err = 0; m_reg = 0; m_be = 0;
    end else begin
      m_rspv = 0;
      if (err_clr) m_err = 0;
      if (m_st == 0) begin
        if (req_valid) begin
          m_reg = int'(req_reg); m_be = req_be; m_tries = 0; m_timer = 0; m_st = 1;
        end
      end else if (m_st == 1) begin
        m_timer = m_timer + 1; m_st = 2;
      end else begin
        int old_t;
        logic [31:0] mask;
        old_t = m_timer;
        m_timer = m_timer + 1;
        for (int b = 0; b < 4; b++) mask[8*b +: 8] = m_be[b] ? 8'hFF : 8'h00;
        if (cpl_valid) begin
          if (cpl_status == 2'd0) begin
            m_rspv = 1; m_rspd = cpl_data & mask; m_tag = "R2"; m_st = 0;
          end else if (cpl_status != 2'd1) begin
            m_rspv = 1; m_rspd = 32'hFFFF_FFFF; m_tag = "R3"; m_st = 0;
          end else if (sw_vis_en && m_reg == 0 && m_be[0] && m_be[1]) begin
            m_rspv = 1; m_rspd = {m_be[3] ? 8'hFF : 8'h00, m_be[2] ? 8'hFF : 8'h00, 16'h0001};
            m_tag = "R4"; m_st = 0;
          end else if (m_tries >= int'(retry_max)) begin
            m_rspv = 1; m_rspd = 32'hFFFF_FFFF; m_err = 1; m_tag = "R7"; m_st = 0;
          end else begin
            m_tries = m_tries + 1; m_st = 1;
          end
        end else if (old_t >= int'(timeout_cyc)) begin
          m_rspv = 1; m_rspd = 32'hFFFF_FFFF; m_err = 1; m_tag = "R8"; m_st = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (m_st == 0), "R1 req_ready", 32'(req_ready), 32'(m_st == 0));
      chk(dn_valid == (m_st == 1), "R5 dn_valid", 32'(dn_valid), 32'(m_st == 1));
      if (dn_valid) begin
        chk(int'(dn_reg) == m_reg && dn_be == m_be, "R1 dn fields",
            {18'h0, dn_be, dn_reg}, {18'h0, m_be, REG_W'(m_reg)});
      end
      chk(rsp_valid == m_rspv, "R11 rsp_valid", 32'(rsp_valid), 32'(m_rspv));
      if (rsp_valid && m_rspv) chk(rsp_data == m_rspd, m_tag, rsp_data, m_rspd);
      chk(err_flag == m_err, "R9 err_flag", 32'(err_flag), 32'(m_err));
    end
  end

  // completion responder: pops a status per downstream request, 4 = stay silent
  int          cpl_q[$];
  int          lat = 2;
  int          cd = 0;
  int          dn_cnt = 0;
  logic [31:0] last_dn_reg = 0;

  always @(negedge clk) begin
    cpl_valid = 1'b0;
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0 && cpl_q.size() > 0) begin
        int s;
        s = cpl_q.pop_front();
        if (s != 4) begin
          cpl_valid = 1'b1;
          cpl_status = 2'(s);
        end
      end
    end else if (dn_valid) begin
      cd = lat;
      dn_cnt++;
      last_dn_reg = 32'(dn_reg);
    end
  end

  task automatic do_read(input int rg, input logic [3:0] be, input logic [31:0] exp,
                         input int exp_issues, input string tag);
    logic [31:0] got;
    bit seen;
    seen = 0; got = 0;
    @(negedge clk);
    dn_cnt = 0;
    req_valid = 1'b1; req_reg = REG_W'(rg); req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (rsp_valid) begin seen = 1; got = rsp_data; end
    end
    chk(seen, {tag, " response seen"}, 32'(seen), 32'd1);
    chk(got == exp, {tag, " data"}, got, exp);
    chk(dn_cnt == exp_issues, {tag, " downstream count"}, 32'(dn_cnt), 32'(exp_issues));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cpl_data = 32'hA5C3_7E19;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !err_flag && !dn_valid, "R1 reset state",
        {28'h0, req_ready, rsp_valid, err_flag, dn_valid}, 32'h8);

    // R2 success, full and partial enables
    cpl_q.push_back(0); do_read(4, 4'hF, 32'hA5C3_7E19, 1, "R2 full");
    cpl_q.push_back(0); do_read(4, 4'b0101, 32'h00C3_0019, 1, "R2 masked");
    // R3 abort / unsupported
    cpl_q.push_back(2); do_read(2, 4'hF, 32'hFFFF_FFFF, 1, "R3 abort");
    cpl_q.push_back(3); do_read(0, 4'hF, 32'hFFFF_FFFF, 1, "R3 unsupported");
    // R4 marker
    sw_vis_en = 1'b1;
    cpl_q.push_back(1); do_read(0, 4'hF, 32'hFFFF_0001, 1, "R4 full marker");
    cpl_q.push_back(1); do_read(0, 4'b0011, 32'h0000_0001, 1, "R4 half marker");
    // R6 visibility on but not both identifier bytes / other register
    cpl_q.push_back(1); cpl_q.push_back(1); cpl_q.push_back(0);
    do_read(0, 4'b1110, 32'hA5C3_7E00, 3, "R6 partial bytes");
    cpl_q.push_back(1); cpl_q.push_back(0);
    do_read(1, 4'hF, 32'hA5C3_7E19, 2, "R6 other register");
    // R5 visibility off
    sw_vis_en = 1'b0;
    lat = 3;
    cpl_q.push_back(1); cpl_q.push_back(1); cpl_q.push_back(0);
    do_read(0, 4'hF, 32'hA5C3_7E19, 3, "R5 reissue");
    // R7 retry limit
    retry_max = 8'd2;
    cpl_q.push_back(1); cpl_q.push_back(1); cpl_q.push_back(1);
    do_read(7, 4'hF, 32'hFFFF_FFFF, 3, "R7 limit two");
    chk(err_flag, "R7 error set", 32'(err_flag), 32'd1);
    // R10 counters restart: two retries allowed again
    cpl_q.push_back(1); cpl_q.push_back(1); cpl_q.push_back(0);
    do_read(7, 4'hF, 32'hA5C3_7E19, 3, "R10 count restart");
    // R9 sticky then cleared
    chk(err_flag, "R9 still set", 32'(err_flag), 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(!err_flag, "R9 cleared", 32'(err_flag), 32'd0);
    // R7 zero limit
    retry_max = 8'd0;
    cpl_q.push_back(1); do_read(3, 4'hF, 32'hFFFF_FFFF, 1, "R7 limit zero");
    chk(err_flag, "R7 error zero limit", 32'(err_flag), 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    // R8 timeout with a silent device
    retry_max = 8'd4; timeout_cyc = 16'd20;
    cpl_q.push_back(4); do_read(5, 4'hF, 32'hFFFF_FFFF, 1, "R8 timeout");
    chk(err_flag, "R8 error set", 32'(err_flag), 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    // R10 timer restart: 15-cycle completion inside a 20-cycle budget
    lat = 15;
    cpl_q.push_back(0); do_read(5, 4'hF, 32'hA5C3_7E19, 1, "R10 timer restart");
    chk(!err_flag, "R10 no error", 32'(err_flag), 32'd0);
    // R1 second request held while busy
    lat = 4;
    cpl_q.push_back(0); cpl_q.push_back(0);
    @(negedge clk);
    dn_cnt = 0;
    req_valid = 1'b1; req_reg = 10'd5; req_be = 4'hF;
    @(negedge clk);
    req_reg = 10'd6;
    chk(!req_ready, "R1 stalled while busy", 32'(req_ready), 32'd0);
    for (int i = 0; i < 200 && !rsp_valid; i++) @(negedge clk);
    chk(dn_cnt == 1, "R1 single outstanding", 32'(dn_cnt), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !rsp_valid; i++) @(negedge clk);
    chk(dn_cnt == 2 && last_dn_reg == 32'd6, "R1 second accepted after first",
        last_dn_reg, 32'd6);
    repeat (5) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule